// File: doc/BRIEF.md
# JTAG Debug Transport Scan Chain

This block is the test access port in front of a debug bus. It runs the standard sixteen-state TAP controller from TCK and TMS. It holds a 5-bit instruction register. The current instruction picks which data register sits between TDI and TDO:

- a 32-bit identification code;
- a 32-bit transport control word;
- a debug-bus access register that is the address width plus 34 bits long.

A debugger uses the access register to send one request per scan. On Update-DR it shifts in an operation, a data word and an address. The block then pulses a strobe and presents the whole shifted word to a downstream access handler. On the next Capture-DR the chain loads the handler's reply word, so the debugger reads the result back during its next scan.

The chain length follows the instruction. Any instruction code with no register behind it acts as a single-bit bypass stage. The TAP state and all shift registers move on the rising edge of TCK. TDO is launched on the falling edge, least significant bit first.

Top module: `dbg_scan_tap`

## Requirements
- R1: While rst_ni is low, and on every cycle spent in Test-Logic-Reset, the instruction is forced to the identification code 0x01. A data scan made after reset, with no instruction scan, returns the IDCODE parameter with bit 0 forced to 1, shifted out LSB first over 32 bits.
- R2: The TAP state follows the IEEE 1149.1 next-state table on the rising edge of TCK. Five cycles with TMS high reach Test-Logic-Reset from any state, which restores the identification instruction. Select-IR-Scan with TMS high goes to Test-Logic-Reset. Update-DR or Update-IR with TMS low goes to Run-Test/Idle.
- R3: Capture-IR loads 5'b00001, so the first five TDO bits of an instruction scan are 1,0,0,0,0. The five TDI bits shifted in become the instruction at Update-IR.
- R4: Instruction 0x10 selects a 32-bit control word with these fields: version 1 in bits [3:0], the address width in bits [9:4], bus status 0 in bits [11:10], idle hint 0 in bits [14:12], and bus-reset 0 in bit 16. All other bits are zero.
- R5: Instruction 0x11 selects a register of ABITS+34 bits that captures rsp_word_i at Capture-DR. A TDI bit appears on TDO exactly ABITS+34 shift cycles later.
- R6: In Update-DR with instruction 0x11, upd_o is high for exactly one TCK cycle. During that cycle upd_word_o holds the last ABITS+34 TDI bits, the first bit shifted landing in bit 0. The fields are the operation in [1:0], data in [33:2] and the address in [ABITS+33:34].
- R7: upd_o stays low for every instruction other than 0x11.
- R8: Any instruction other than 0x01, 0x10 and 0x11 selects a 1-bit register that captures 0, so TDO repeats TDI one shift later.
- R9: TDO changes only on the falling edge of TCK.
- R10: Leaving Shift-DR for Pause-DR and returning through Exit2-DR leaves the chain contents unchanged, so a paused scan gives the same result as an unbroken one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset into Test-Logic-Reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial data in |
| rsp_word_i | input | ABITS+34 | Access handler reply, captured into the access register |
| tdo_o | output | 1 | Serial data out, launched on the falling TCK edge |
| upd_o | output | 1 | Access request strobe during Update-DR |
| upd_word_o | output | ABITS+34 | Shifted access word presented with upd_o |

## Verification
The access register is scanned with random request words and random reply words. Some scans are paused at a random bit and some are not. This separates a correct field capture and update from a chain that drops or duplicates bits across Pause-DR. An over-length scan is used to pin the chain length exactly, because the surplus TDO bits must be the first TDI bits. Directed scans of the identification code, the control word and an unused instruction tell the three register lengths and the bypass stage apart. A random TMS walk followed by five TMS-high cycles shows that the controller always returns to reset and restores the identification instruction.

// File: rtl/dbg_scan_tap_pkg.sv
package dbg_scan_tap_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE, TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR,
    TS_UPD_DR, TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_st_e;

  localparam int unsigned IR_W = 5;
  localparam logic [IR_W-1:0] INS_ID  = 5'h01;
  localparam logic [IR_W-1:0] INS_CTL = 5'h10;
  localparam logic [IR_W-1:0] INS_ACC = 5'h11;
  localparam logic [IR_W-1:0] IR_CAP  = 5'b00001;

  function automatic tap_st_e tap_next(tap_st_e s, logic tms);
    unique case (s)
      TS_RESET:    return tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     return tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   return tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   return tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: return tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: return tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: return tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: return tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   return tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   return tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   return tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: return tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: return tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: return tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: return tms ? TS_UPD_IR   : TS_SHIFT_IR;
      default:     return tms ? TS_SEL_DR   : TS_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/dbg_scan_tap_fsm.sv
module dbg_scan_tap_fsm
  import dbg_scan_tap_pkg::*;
(
  input  logic    tck_i,
  input  logic    rst_ni,
  input  logic    tms_i,
  output tap_st_e st_o
);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) st_o <= TS_RESET;
    else         st_o <= tap_next(st_o, tms_i);
  end

endmodule

// File: rtl/dbg_scan_tap_ir.sv
module dbg_scan_tap_ir
  import dbg_scan_tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_st_e         st_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            lsb_o
);

  logic [IR_W-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= IR_CAP;
      ir_o <= INS_ID;
    end else begin
      unique case (st_i)
        TS_CAP_IR:   sr_q <= IR_CAP;
        TS_SHIFT_IR: sr_q <= {tdi_i, sr_q[IR_W-1:1]};
        default:     ;
      endcase
      if (st_i == TS_RESET)       ir_o <= INS_ID;
      else if (st_i == TS_UPD_IR) ir_o <= sr_q;
    end
  end

  assign lsb_o = sr_q[0];

endmodule

// File: rtl/dbg_scan_tap_dr.sv
module dbg_scan_tap_dr
  import dbg_scan_tap_pkg::*;
#(
  parameter int unsigned ABITS  = 7,
  parameter logic [31:0] IDCODE = 32'h1000_0A5F,
  localparam int unsigned DW    = ABITS + 34,
  localparam int unsigned SRW   = (DW > 32) ? DW : 32,
  localparam int unsigned LW    = $clog2(SRW + 1)
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_st_e         st_i,
  input  logic [IR_W-1:0] ir_i,
  input  logic            tdi_i,
  input  logic [DW-1:0]   rsp_word_i,
  output logic            lsb_o,
  output logic [LW-1:0]   len_o,
  output logic            upd_o,
  output logic [DW-1:0]   word_o
);

  localparam logic [31:0] ID_WORD  = {IDCODE[31:1], 1'b1};
  localparam logic [31:0] CTL_WORD = {15'd0, 1'b0, 1'b0, 3'd0, 2'd0, 6'(ABITS), 4'd1};

  logic [SRW-1:0] sr_q, cap_val, shf_val;
  logic [LW-1:0]  cap_len;

  always_comb begin
    cap_val = '0;
    unique case (ir_i)
      INS_ID:  begin cap_val[31:0]   = ID_WORD;    cap_len = LW'(32); end
      INS_CTL: begin cap_val[31:0]   = CTL_WORD;   cap_len = LW'(32); end
      INS_ACC: begin cap_val[DW-1:0] = rsp_word_i; cap_len = LW'(DW); end
      default: cap_len = LW'(1);
    endcase
  end

  // TDI enters at the top of the active length
  always_comb begin
    shf_val = sr_q >> 1;
    for (int i = 0; i < SRW; i++)
      if (i == int'(len_o) - 1) shf_val[i] = tdi_i;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      len_o <= LW'(32);
    end else if (st_i == TS_CAP_DR) begin
      sr_q  <= cap_val;
      len_o <= cap_len;
    end else if (st_i == TS_SHIFT_DR) begin
      sr_q  <= shf_val;
    end
  end

  assign lsb_o  = sr_q[0];
  assign upd_o  = (st_i == TS_UPD_DR) && (ir_i == INS_ACC);
  assign word_o = sr_q[DW-1:0];

endmodule

// File: rtl/dbg_scan_tap.sv
module dbg_scan_tap
  import dbg_scan_tap_pkg::*;
#(
  parameter int unsigned ABITS  = 7,
  parameter logic [31:0] IDCODE = 32'h1000_0A5F
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  input  logic [ABITS+33:0] rsp_word_i,
  output logic              tdo_o,
  output logic              upd_o,
  output logic [ABITS+33:0] upd_word_o
);

  localparam int unsigned DW  = ABITS + 34;
  localparam int unsigned SRW = (DW > 32) ? DW : 32;
  localparam int unsigned LW  = $clog2(SRW + 1);

  tap_st_e         st_q;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, dr_lsb;
  logic [LW-1:0]   dr_len;

  dbg_scan_tap_fsm u_fsm (
    .tck_i, .rst_ni, .tms_i, .st_o(st_q)
  );

  dbg_scan_tap_ir u_ir (
    .tck_i, .rst_ni, .st_i(st_q), .tdi_i, .ir_o(ir_q), .lsb_o(ir_lsb)
  );

  dbg_scan_tap_dr #(.ABITS(ABITS), .IDCODE(IDCODE)) u_dr (
    .tck_i, .rst_ni, .st_i(st_q), .ir_i(ir_q), .tdi_i, .rsp_word_i,
    .lsb_o(dr_lsb), .len_o(dr_len), .upd_o, .word_o(upd_word_o)
  );

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) tdo_o <= 1'b0;
    else begin
      unique case (st_q)
        TS_SHIFT_DR: tdo_o <= dr_lsb;
        TS_SHIFT_IR: tdo_o <= ir_lsb;
        default:     tdo_o <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/dbg_scan_tap_chk.sv
module dbg_scan_tap_chk
  import dbg_scan_tap_pkg::*;
#(
  parameter int unsigned ABITS = 7,
  localparam int unsigned DW   = ABITS + 34,
  localparam int unsigned SRW  = (DW > 32) ? DW : 32,
  localparam int unsigned LW   = $clog2(SRW + 1)
) (
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tms_i,
  input tap_st_e         st_i,
  input logic [IR_W-1:0] ir_i,
  input logic [LW-1:0]   len_i,
  input logic            upd_i
);

  AST_RESET_IR_ID: assert property (@(posedge tck_i) disable iff (!rst_ni)
    st_i == TS_RESET |=> ir_i == INS_ID); // R1
  AST_SELIR_TO_RESET: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (st_i == TS_SEL_IR && tms_i) |=> st_i == TS_RESET); // R2
  AST_UPD_TO_IDLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ((st_i == TS_UPD_DR || st_i == TS_UPD_IR) && !tms_i) |=> st_i == TS_IDLE); // R2
  AST_ID_LEN: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (st_i == TS_SHIFT_DR && (ir_i == INS_ID || ir_i == INS_CTL)) |-> len_i == LW'(32)); // R4
  AST_ACC_LEN: assert property (@(posedge tck_i) disable iff (!rst_ni)
    upd_i |-> len_i == LW'(DW)); // R5
  AST_UPD_PULSE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    upd_i |=> !upd_i); // R6
  AST_UPD_ACC_ONLY: assert property (@(posedge tck_i) disable iff (!rst_ni)
    upd_i |-> ir_i == INS_ACC); // R7
  AST_BYPASS_LEN: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (st_i == TS_SHIFT_DR && ir_i != INS_ID && ir_i != INS_CTL && ir_i != INS_ACC)
      |-> len_i == LW'(1)); // R8

endmodule

bind dbg_scan_tap dbg_scan_tap_chk #(.ABITS(ABITS)) u_chk (
  .tck_i(tck_i), .rst_ni(rst_ni), .tms_i(tms_i), .st_i(st_q), .ir_i(ir_q),
  .len_i(dr_len), .upd_i(upd_o)
);

// File: tb/sim_dbg_scan_tap.sv
module sim_dbg_scan_tap;

  localparam int unsigned ABITS = 7;
  localparam int unsigned DW    = ABITS + 34;
  localparam logic [31:0] IDC   = 32'h2468_ACE0;
  localparam logic [63:0] MSK   = (64'd1 << DW) - 64'd1;

  logic tck = 1'b0, rst_ni = 1'b0, tms_i = 1'b1, tdi_i = 1'b0;
  logic [DW-1:0] rsp_word_i = '0;
  logic tdo_o, upd_o;
  logic [DW-1:0] upd_word_o;

  int checks = 0, errors = 0, r9_bad = 0;

  always #5 tck = ~tck;

  dbg_scan_tap #(.ABITS(ABITS), .IDCODE(IDC)) u0 (
    .tck_i(tck), .rst_ni, .tms_i, .tdi_i, .rsp_word_i, .tdo_o, .upd_o, .upd_word_o
  );

  function automatic logic [63:0] exp_id();
    return 64'({IDC[31:1], 1'b1});
  endfunction

  function automatic logic [63:0] exp_ctl();
    return 64'((ABITS << 4) | 1);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic tms, input logic tdi);
    logic pre;
    tms_i = tms;
    tdi_i = tdi;
    pre = tdo_o;
    @(posedge tck);
    #1;
    if (tdo_o !== pre) r9_bad++;
    @(negedge tck);
    #1;
  endtask

  task automatic scan_ir(input logic [4:0] din, output logic [4:0] dout);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) begin
      dout[i] = tdo_o;
      tick(i == 4, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input int pause_at,
                         output logic [63:0] dout, output logic seen,
                         output logic [63:0] w, output logic after);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo_o;
      tick((i == n - 1) || (i == pause_at), din[i]);
      if (i == pause_at && i != n - 1) begin
        tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
      end
    end
    tick(1, 0);
    seen = upd_o;
    w = 64'(upd_word_o);
    tick(0, 0);
    after = upd_o;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] dout, w, din, rsp;
    logic [4:0] iout;
    logic seen, after;
    int pa;
    void'($urandom(32'h5eed));

    repeat (3) @(negedge tck);
    #1;
    chk("R1 reset tdo", 64'(tdo_o), 0);
    chk("R1 reset upd", 64'(upd_o), 0);
    rst_ni = 1'b1;
    tick(0, 0);

    // R1 identification after reset without instruction scan
    scan_dr(32, 0, -1, dout, seen, w, after);
    chk("R1 idcode", dout, exp_id());

    // R3 capture pattern, R4 control word, R7 no strobe
    scan_ir(5'h10, iout);
    chk("R3 ir capture", 64'(iout), 64'h01);
    scan_dr(32, 64'hffff_ffff, -1, dout, seen, w, after);
    chk("R4 control word", dout, exp_ctl());
    chk("R7 no strobe on control", 64'(seen), 0);

    // R2 five TMS-high cycles restore identification
    repeat (5) tick(1, 0);
    tick(0, 0);
    scan_dr(32, 0, -1, dout, seen, w, after);
    chk("R2 reset restores idcode", dout, exp_id());

    // R5 R6 R10 random access scans
    scan_ir(5'h11, iout);
    chk("R3 ir capture again", 64'(iout), 64'h01);
    for (int k = 0; k < 16; k++) begin
      din = {32'($urandom), 32'($urandom)} & MSK;
      rsp = {32'($urandom), 32'($urandom)} & MSK;
      pa = (k % 2 == 1) ? int'($urandom % DW) : -1;
      rsp_word_i = rsp[DW-1:0];
      scan_dr(DW, din, pa, dout, seen, w, after);
      chk(pa >= 0 ? "R10 R5 paused capture" : "R5 capture reply", dout, rsp);
      chk("R6 strobe", 64'(seen), 1);
      chk(pa >= 0 ? "R10 R6 paused word" : "R6 word", w, din);
      chk("R6 strobe one cycle", 64'(after), 0);
    end

    // R5 over-length scan pins chain length
    din = {32'($urandom), 32'($urandom)} & ((64'd1 << (DW + 5)) - 1);
    rsp = {32'($urandom), 32'($urandom)} & MSK;
    rsp_word_i = rsp[DW-1:0];
    scan_dr(DW + 5, din, -1, dout, seen, w, after);
    chk("R5 length head", dout & MSK, rsp);
    chk("R5 length tail", (dout >> DW) & 64'h1f, din & 64'h1f);
    chk("R6 word after overlength", w, (din >> 5) & MSK);

    // R8 bypass for unused code, R7 no strobe
    scan_ir(5'h05, iout);
    din = 64'($urandom) & 64'hff;
    scan_dr(8, din, -1, dout, seen, w, after);
    chk("R8 bypass captures 0", dout & 64'h1, 0);
    chk("R8 bypass delay", (dout >> 1) & 64'h7f, din & 64'h7f);
    chk("R7 no strobe on bypass", 64'(seen), 0);

    // R3 explicit identification instruction
    scan_ir(5'h01, iout);
    scan_dr(32, 0, -1, dout, seen, w, after);
    chk("R3 ir 0x01 selects idcode", dout, exp_id());

    // R2 random TMS walk then reset
    for (int k = 0; k < 40; k++) tick(1'($urandom), 1'($urandom));
    repeat (5) tick(1, 0);
    tick(0, 0);
    scan_dr(32, 0, -1, dout, seen, w, after);
    chk("R2 walk then reset", dout, exp_id());
    chk("R7 no strobe on idcode", 64'(seen), 0);

    chk("R9 tdo stable across rising edge", 64'(r9_bad), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule